// File: doc/BRIEF.md
# Clock Frequency Tuning Controller

This controller closes the loop between timing-margin detectors in a block of user logic and the reconfigurable clock generator that feeds that logic. Each pulse on the detector input is counted. When the count reaches a programmable threshold, the controller moves a pointer into a table of frequency settings. The same happens on a host request or at a batch boundary in automatic mode. The controller then streams that setting's three configuration words to the clock generator and waits for the generator to report lock. Table index 0 is the fastest setting, and a higher index means a slower clock.

The host uses a small register interface with four word addresses. Address 0 is the command register, address 1 the activation threshold, and address 2 the signed step. Address 3 is a read-only status word that returns the table index and the activation count. The table is not stored. Each configuration word is computed from its address, so the table has no memory cost. The controller also drives an enable for the user logic and a clock-stop output that gates the user clock domain.

Top module: `freq_tune_ctrl`

## Requirements
- R1: After reset the table index is START_IDX (100 by default), the activation count is 0, the threshold reads 1 and the step reads 3. The command register reads 0, and busy, cfg_valid, user_en and clk_stop are low.
- R2: Command bit 0 drives user_en, command bit 4 drives clk_stop, and command bit 1 selects automatic mode. A read of address 0 returns these three bits in the same positions and returns zero in every other bit.
- R3: While command bit 0 is set and the controller is idle, each cycle with det_act high adds one to the count. With bit 0 clear, no activation is counted. A command write with bit 2 set adds one forced activation. The count is read from bits 15:0 of address 3.
- R4: A command write with bit 3 set clears the count. If a detector activation arrives in the same cycle, the clear wins and the count becomes 0.
- R5: Writing 0 to the threshold register stores 1. Any other value is stored as written.
- R6: In manual mode (bit 0 set, bit 1 clear), a count at or above the threshold starts a retune. The new index is the old index plus step/3: a step of +3n slows the clock by n settings, and a step of -3n speeds it up by n settings.
- R7: The new index saturates at 0 and at N_SET-1 (485 by default) and never wraps.
- R8: A retune raises busy and drives cfg_valid for three consecutive cycles, with cfg_addr equal to 3*idx, 3*idx+1 and 3*idx+2. Each cfg_data is ((addr*40503) XOR 23130) mod 65536. Busy then holds until cm_locked is seen. On lock, the count is cleared and busy falls. The index is read from bits 31:16 of address 3.
- R9: In automatic mode (bits 0 and 1 set), reaching the threshold alone starts nothing. On a batch_done pulse the index moves up by one if the count is at or above the threshold, and down by one otherwise.
- R10: A command write with bit 5 set starts a retune by step/3 even while bit 0 is clear.
- R11: Writes to the threshold and step registers are ignored while busy is high.
- R12: Detector activations that arrive while busy is high are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| det_act | input | 1 | Detector activation pulse |
| batch_done | input | 1 | Batch boundary pulse for automatic mode |
| cm_locked | input | 1 | Clock generator lock indication |
| cfg_valid | output | 1 | Configuration word strobe |
| cfg_addr | output | ADDR_W (11) | Table word address |
| cfg_data | output | WORD_W (16) | Configuration word |
| busy | output | 1 | Retune sequence in progress |
| user_en | output | 1 | User logic and detector enable |
| clk_stop | output | 1 | Clock-gated idle request |

## Verification
Two functions can act on the activation counter in the same cycle: a detector pulse tries to increment it while a clear command tries to zero it. The bench builds a nonzero count first. It then drives det_act high in the same cycle that it writes the clear command, and it passes only if the count reads back as zero. A second overlap comes from sending detector pulses and register writes while a retune is stalled waiting for lock. Reading the registers back afterwards shows that the count, threshold and step are all unchanged.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SEND = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_t;

  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_THR  = 2'd1;
  localparam logic [1:0] RA_STEP = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;

  localparam int CB_EN     = 0;
  localparam int CB_AUTO   = 1;
  localparam int CB_FORCE  = 2;
  localparam int CB_CLEAR  = 3;
  localparam int CB_STOP   = 4;
  localparam int CB_RETUNE = 5;

  localparam int WORDS_PER_SET = 3;

  // configuration word generated from its table address
  function automatic logic [31:0] ftc_word(input logic [31:0] a);
    logic [31:0] p;
    p = a * 32'h0000_9E37;
    return p ^ 32'h0000_5A5A;
  endfunction

  // signed step register value to index offset
  function automatic int ftc_step_delta(input logic signed [31:0] s);
    logic signed [31:0] q;
    q = s / 32'sd3;
    return int'(q);
  endfunction

  // saturating index update
  function automatic int ftc_clamp(input int cur, input int d, input int n);
    int t;
    t = cur + d;
    if (t < 0) t = 0;
    else if (t > n - 1) t = n - 1;
    return t;
  endfunction

endpackage

// File: rtl/ftc_regs.sv
module ftc_regs
  import ftc_pkg::*;
#(
  parameter int THR_W  = 16,
  parameter int STEP_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [1:0]               addr,
  input  logic [31:0]              wdata,
  input  logic                     busy,
  output logic                     cmd_en,
  output logic                     cmd_auto,
  output logic                     cmd_stop,
  output logic                     pulse_force,
  output logic                     pulse_clear,
  output logic                     pulse_retune,
  output logic [THR_W-1:0]         thr,
  output logic signed [STEP_W-1:0] step
);

  logic cmd_wr, thr_wr, step_wr, thr_zero;
  logic unused_wdata;

  assign cmd_wr   = we && (addr == RA_CMD);
  assign thr_wr   = we && (addr == RA_THR) && !busy;
  assign step_wr  = we && (addr == RA_STEP) && !busy;
  assign thr_zero = (wdata[THR_W-1:0] == '0);
  assign unused_wdata = ^wdata;

  assign pulse_force  = cmd_wr && wdata[CB_FORCE];
  assign pulse_clear  = cmd_wr && wdata[CB_CLEAR];
  assign pulse_retune = cmd_wr && wdata[CB_RETUNE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_en   <= 1'b0;
      cmd_auto <= 1'b0;
      cmd_stop <= 1'b0;
      thr      <= THR_W'(1);
      step     <= STEP_W'(3);
    end else begin
      if (cmd_wr) begin
        cmd_en   <= wdata[CB_EN];
        cmd_auto <= wdata[CB_AUTO];
        cmd_stop <= wdata[CB_STOP];
      end
      if (thr_wr) thr <= thr_zero ? THR_W'(1) : wdata[THR_W-1:0];
      if (step_wr) step <= wdata[STEP_W-1:0];
    end
  end

  assert_thr_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == RA_THR && !busy && thr_zero) |=> (thr == THR_W'(1)));

  assert_thr_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == RA_THR && busy) |=> $stable(thr));

  assert_step_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == RA_STEP && busy) |=> $stable(step));

endmodule

// File: rtl/ftc_act_cnt.sv
module ftc_act_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             act,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic at_max, bump;

  assign at_max = (cnt == CNT_MAX);
  assign bump   = count_en && act && !at_max;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (bump) cnt <= cnt + 1'b1;
  end

  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && act && !clr && !at_max) |=> (cnt == $past(cnt) + 1'b1));

  assert_count_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !clr) |=> $stable(cnt));

endmodule

// File: rtl/ftc_seq.sv
module ftc_seq
  import ftc_pkg::*;
#(
  parameter int N_SET     = 486,
  parameter int START_IDX = 100,
  parameter int IDX_W     = 9,
  parameter int ADDR_W    = 11,
  parameter int WORD_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  target,
  input  logic              cm_locked,
  output logic              busy,
  output logic [IDX_W-1:0]  idx,
  output logic              cfg_valid,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [WORD_W-1:0] cfg_data,
  output logic              done
);

  localparam logic [1:0] LAST_K = 2'(WORDS_PER_SET - 1);

  sq_state_t  st;
  logic [1:0] k;
  logic [ADDR_W-1:0] base_addr;

  assign busy      = (st != SQ_IDLE);
  assign cfg_valid = (st == SQ_SEND);
  assign done      = (st == SQ_WAIT) && cm_locked;
  assign base_addr = ADDR_W'(idx) * ADDR_W'(WORDS_PER_SET);
  assign cfg_addr  = base_addr + ADDR_W'(k);
  assign cfg_data  = WORD_W'(ftc_word(32'(cfg_addr)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      k   <= 2'd0;
      idx <= IDX_W'(START_IDX);
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          idx <= target;
          k   <= 2'd0;
          st  <= SQ_SEND;
        end
        SQ_SEND: begin
          if (k == LAST_K) st <= SQ_WAIT;
          else k <= k + 2'd1;
        end
        SQ_WAIT: if (cm_locked) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx < IDX_W'(N_SET)));

  assert_first_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cfg_valid && cfg_addr == base_addr));

  assert_word_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && $past(cfg_valid)) |-> (cfg_addr == $past(cfg_addr) + 1'b1));

  assert_wait_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_valid && !cm_locked) |=> busy);

endmodule

// File: rtl/freq_tune_ctrl.sv
module freq_tune_ctrl
  import ftc_pkg::*;
#(
  parameter int N_SET     = 486,
  parameter int START_IDX = 100,
  parameter int CNT_W     = 16,
  parameter int THR_W     = 16,
  parameter int STEP_W    = 16,
  parameter int WORD_W    = 16,
  localparam int IDX_W    = $clog2(N_SET),
  localparam int ADDR_W   = $clog2(WORDS_PER_SET * N_SET)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              det_act,
  input  logic              batch_done,
  input  logic              cm_locked,
  output logic              cfg_valid,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [WORD_W-1:0] cfg_data,
  output logic              busy,
  output logic              user_en,
  output logic              clk_stop
);

  logic cmd_en, cmd_auto, cmd_stop;
  logic pulse_force, pulse_clear, pulse_retune;
  logic [THR_W-1:0] thr;
  logic signed [STEP_W-1:0] step;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx, target;
  logic seq_done, thr_hit, idle;
  logic start_host, start_man, start_auto, start;
  logic signed [31:0] step_ext;
  int delta;

  ftc_regs #(.THR_W(THR_W), .STEP_W(STEP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .cmd_en(cmd_en), .cmd_auto(cmd_auto), .cmd_stop(cmd_stop),
    .pulse_force(pulse_force), .pulse_clear(pulse_clear),
    .pulse_retune(pulse_retune), .thr(thr), .step(step)
  );

  ftc_act_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .count_en(cmd_en && !busy),
    .act(det_act || pulse_force), .clr(pulse_clear || seq_done), .cnt(cnt)
  );

  ftc_seq #(
    .N_SET(N_SET), .START_IDX(START_IDX), .IDX_W(IDX_W),
    .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .target(target),
    .cm_locked(cm_locked), .busy(busy), .idx(idx), .cfg_valid(cfg_valid),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .done(seq_done)
  );

  // retune decision
  assign idle       = !busy;
  assign thr_hit    = (32'(cnt) >= 32'(thr));
  assign start_host = idle && pulse_retune;
  assign start_man  = idle && cmd_en && !cmd_auto && thr_hit;
  assign start_auto = idle && cmd_en && cmd_auto && batch_done;
  assign start      = start_host || start_man || start_auto;
  assign step_ext   = 32'(step);

  always_comb begin
    if (start_host || start_man) delta = ftc_step_delta(step_ext);
    else if (thr_hit)            delta = 1;
    else                         delta = -1;
    target = IDX_W'(ftc_clamp(int'(idx), delta, N_SET));
  end

  assign user_en  = cmd_en;
  assign clk_stop = cmd_stop;

  always_comb begin
    case (reg_addr)
      RA_CMD:  reg_rdata = 32'({cmd_stop, 2'b00, cmd_auto, cmd_en});
      RA_THR:  reg_rdata = 32'(thr);
      RA_STEP: reg_rdata = step_ext;
      default: reg_rdata = {16'(idx), 16'(cnt)};
    endcase
  end

  assert_manual_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cmd_en && !cmd_auto && thr_hit) |=> busy);

  assert_auto_defers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cmd_auto && !batch_done && !pulse_retune) |=> !busy);

  assert_host_fire_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pulse_retune) |=> busy);

  assert_lock_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (cnt == '0 && !busy));

endmodule

// File: tb/sim_freq_tune_ctrl.sv
module sim_freq_tune_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic det_act = 1'b0;
  logic batch_done = 1'b0;
  logic cm_locked = 1'b1;
  logic cfg_valid;
  logic [10:0] cfg_addr;
  logic [15:0] cfg_data;
  logic busy, user_en, clk_stop;

  int checks = 0;
  int errs = 0;
  int mon_n = 0;
  logic [31:0] mon_a [8];
  logic [31:0] mon_d [8];

  always #10 clk = ~clk;

  freq_tune_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .det_act(det_act),
    .batch_done(batch_done), .cm_locked(cm_locked), .cfg_valid(cfg_valid),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .busy(busy),
    .user_en(user_en), .clk_stop(clk_stop)
  );

  always @(posedge clk) begin
    if (cfg_valid && mon_n < 8) begin
      mon_a[mon_n] = 32'(cfg_addr);
      mon_d[mon_n] = 32'(cfg_data);
      mon_n = mon_n + 1;
    end
  end

  function automatic logic [31:0] exp_word(input int a);
    return ((a * 40503) ^ 23130) & 32'h0000_FFFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_det(input int n);
    @(negedge clk);
    det_act = 1'b1;
    repeat (n) @(negedge clk);
    det_act = 1'b0;
  endtask

  task automatic wait_busy();
    for (int i = 0; i < 20 && !busy; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  task automatic check_words(input string req, input int idx);
    chk(req, 32'(mon_n), 32'd3);
    for (int k = 0; k < 3; k++) begin
      chk(req, mon_a[k], 32'(idx * 3 + k));
      chk(req, mon_d[k], exp_word(idx * 3 + k));
    end
  endtask

  task automatic check_stat(input string req, input int idx, input int cnt);
    logic [31:0] s;
    rd(2'd3, s);
    chk(req, 32'(s[31:16]), 32'(idx));
    chk(req, 32'(s[15:0]), 32'(cnt));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check_stat("R1 status", 100, 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 cfg_valid", 32'(cfg_valid), 0);
    chk("R1 user_en", 32'(user_en), 0);
    chk("R1 clk_stop", 32'(clk_stop), 0);
    rd(2'd0, v); chk("R1 cmd", v, 0);
    rd(2'd1, v); chk("R1 thr", v, 1);
    rd(2'd2, v); chk("R1 step", v, 3);
  endtask

  task automatic t_cmd();
    logic [31:0] v;
    wr(2'd0, 32'h13);
    chk("R2 user_en", 32'(user_en), 1);
    chk("R2 clk_stop", 32'(clk_stop), 1);
    rd(2'd0, v); chk("R2 cmd readback", v, 32'h13);
    wr(2'd0, 32'h0);
    chk("R2 user_en off", 32'(user_en), 0);
    chk("R2 clk_stop off", 32'(clk_stop), 0);
  endtask

  task automatic t_count();
    wr(2'd1, 32'd1000);
    pulse_det(3);
    check_stat("R3 disabled", 100, 0);
    wr(2'd0, 32'h1);
    pulse_det(4);
    check_stat("R3 counted", 100, 4);
    wr(2'd0, 32'h5);
    check_stat("R3 forced", 100, 5);
  endtask

  task automatic t_clear();
    @(negedge clk);
    det_act = 1'b1; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h9;
    @(negedge clk);
    det_act = 1'b0; reg_we = 1'b0;
    check_stat("R4 clear beats activation", 100, 0);
    pulse_det(1);
    check_stat("R4 counting after clear", 100, 1);
    wr(2'd0, 32'h9);
    check_stat("R4 plain clear", 100, 0);
  endtask

  task automatic t_thr();
    logic [31:0] v;
    wr(2'd1, 32'd0);
    rd(2'd1, v); chk("R5 zero floor", v, 1);
    wr(2'd1, 32'd1000);
    rd(2'd1, v); chk("R5 value kept", v, 1000);
  endtask

  task automatic t_manual();
    wr(2'd1, 32'd2);
    wr(2'd2, 32'd3);
    mon_n = 0;
    pulse_det(2);
    wait_busy(); wait_idle();
    check_words("R8 words slower", 101);
    check_stat("R6 step +3", 101, 0);
    wr(2'd2, 32'hFFFF_FFFA);
    mon_n = 0;
    pulse_det(2);
    wait_busy(); wait_idle();
    check_words("R8 words faster", 99);
    check_stat("R6 step -6", 99, 0);
    wr(2'd1, 32'd1000);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_sat();
    wr(2'd2, 32'd1800);
    mon_n = 0;
    wr(2'd0, 32'h20);
    wait_busy(); wait_idle();
    check_words("R7 top words", 485);
    check_stat("R7 R10 top clamp", 485, 0);
    wr(2'd2, 32'hFFFF_F448);
    wr(2'd0, 32'h20);
    wait_busy(); wait_idle();
    check_stat("R7 bottom clamp", 0, 0);
    wr(2'd2, 32'hFFFF_FFFD);
    wr(2'd0, 32'h20);
    wait_busy(); wait_idle();
    check_stat("R7 hold at zero", 0, 0);
    wr(2'd2, 32'd300);
    wr(2'd0, 32'h20);
    wait_busy(); wait_idle();
    check_stat("R10 host retune", 100, 0);
  endtask

  task automatic t_auto();
    wr(2'd1, 32'd3);
    wr(2'd0, 32'h3);
    pulse_det(5);
    repeat (3) @(negedge clk);
    chk("R9 no early retune", 32'(busy), 0);
    check_stat("R9 count held", 100, 5);
    @(negedge clk); batch_done = 1'b1;
    @(negedge clk); batch_done = 1'b0;
    wait_busy(); wait_idle();
    check_stat("R9 slow down", 101, 0);
    @(negedge clk); batch_done = 1'b1;
    @(negedge clk); batch_done = 1'b0;
    wait_busy(); wait_idle();
    check_stat("R9 speed up", 100, 0);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd1000);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    wr(2'd2, 32'd3);
    cm_locked = 1'b0;
    wr(2'd0, 32'h21);
    wait_busy();
    repeat (10) @(negedge clk);
    chk("R8 waits for lock", 32'(busy), 1);
    wr(2'd1, 32'd7);
    wr(2'd2, 32'hFFFF_FFFA);
    pulse_det(3);
    rd(2'd1, v); chk("R11 thr frozen", v, 1000);
    rd(2'd2, v); chk("R11 step frozen", v, 3);
    check_stat("R12 no count while busy", 101, 0);
    cm_locked = 1'b1;
    wait_idle();
    chk("R8 lock releases", 32'(busy), 0);
    check_stat("R8 after lock", 101, 0);
    wr(2'd2, 32'hFFFF_FFFD);
    rd(2'd2, v); chk("R11 idle write", v, 32'hFFFF_FFFD);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cmd();
    t_count();
    t_clear();
    t_thr();
    t_manual();
    t_sat();
    t_auto();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule